// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block decides the outcome of load-linked / store-conditional atomics in a small group of cores. Each core owns one reservation. A load-exclusive sets it to the line that holds the target address. The monitor watches every core's stores and a shared snoop channel, and any remote write or ownership loss that touches a reserved line clears that reservation. When a core issues a store-exclusive, the monitor grants it only while that core's reservation is still live and covers the same line.

All core requests are sampled in the same cycle. One cycle later the monitor reports each store-exclusive's status, where 0 means success and 1 means failure. It also forwards each write that may reach memory, on a per-core write port with the original address and data. A failed store-exclusive never reaches the write port. Plain stores always reach it.

The parameter `SELF_STORE_BREAKS` decides whether a core's own plain store to its reserved line clears that reservation. The parameter `HOLD` sets a bounded hold-off. When `HOLD` is above zero, a remote snoop that hits a live reservation is not acknowledged for up to `HOLD` cycles. That gap gives the owner time to complete its store-exclusive.

Top module: `llsc_monitor`

## Requirements
- R1: Reservations have line granularity, with `LINE_BYTES` = 64. A store-exclusive to any address in the reserved line is a hit, for example 0x1038 after a load-exclusive to 0x1000. A store-exclusive to another line fails, for example 0x1040.
- R2: The response to a store-exclusive appears exactly one cycle after the request, on `rsp_valid`. A success shows `rsp_fail` = 0 and raises `mem_we` with the request's address and data. A failure shows `rsp_fail` = 1 with `mem_we` low. After reset all outputs are low.
- R3: A store-exclusive issued by a core with no live reservation fails.
- R4: A plain store from another core to the reserved line clears the reservation. A plain store from another core to a different line leaves it intact.
- R5: With `SELF_STORE_BREAKS` = 1, the owner's own plain store to its reserved line clears the reservation. With 0, the reservation survives.
- R6: An acknowledged snoop to the reserved line from another core clears the reservation. A snoop whose `snp_src` is the owner neither clears the reservation nor is delayed.
- R7: A snoop that hits a reservation of another core is acknowledged once it has waited `HOLD` cycles. With `HOLD` = 4 that is 4 unacknowledged cycles, then `snp_ack`. It never waits longer. If the reservation clears earlier, the acknowledgement comes in the next cycle. With `HOLD` = 0 the acknowledgement is immediate.
- R8: Every store-exclusive clears its issuer's reservation, whether it succeeds or fails. A new load-exclusive replaces the previous reservation of that core.
- R9: When several store-exclusives with live reservations target one line in the same cycle, only the lowest-index core succeeds. Store-exclusives to different lines in the same cycle can all succeed.
- R10: A plain store (`req_op` = 1) is always forwarded on `mem_we` one cycle later and produces no `rsp_valid`. Op code 0 is idle, 2 is load-exclusive and 3 is store-exclusive.
- R11: Three cores retry load-exclusive / store-exclusive on one line against a continuous snoop from a fourth core. With `HOLD` = 4 every core succeeds, and core k needs exactly k retries. With `HOLD` = 0 none succeeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_op | input | 2*N | Per-core op: 0 idle, 1 store, 2 load-exclusive, 3 store-exclusive |
| req_addr | input | N*AW | Per-core byte address |
| req_wdata | input | N*DW | Per-core write data |
| snp_valid | input | 1 | Snoop request, held until acknowledged |
| snp_src | input | $clog2(N) | Index of the core gaining the line |
| snp_line | input | AW-$clog2(LINE_BYTES) | Line address of the snoop |
| snp_ack | output | 1 | Snoop accepted this cycle |
| rsp_valid | output | N | Store-exclusive status valid, per core |
| rsp_fail | output | N | Store-exclusive status: 1 failed, 0 succeeded |
| mem_we | output | N | Forwarded write enable, per core |
| mem_addr | output | N*AW | Forwarded write address |
| mem_wdata | output | N*DW | Forwarded write data |

## Verification
Two pairs of events can land in the same cycle. The first pair is a store-exclusive and a clearing event on the same line. The bench provokes this with two cores that reserve one line in the same cycle and then store-exclusive it in the same cycle, and it expects exactly one success, at the lower index. The second pair is a store-exclusive and a held snoop. The bench raises the snoop in the same cycle as the store-exclusive and checks two things: the write succeeds, and the acknowledgement comes one cycle later instead of after the full hold-off. A scoreboard compares every status and forwarded write against the expected value, while the wait before each acknowledgement is counted at the ports.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int N                 = 4,
  parameter int AW                = 32,
  parameter int DW                = 32,
  parameter int LINE_BYTES        = 64,
  parameter int SELF_STORE_BREAKS = 1,
  parameter int HOLD              = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [2*N-1:0]                    req_op,
  input  logic [N*AW-1:0]                   req_addr,
  input  logic [N*DW-1:0]                   req_wdata,
  input  logic                              snp_valid,
  input  logic [$clog2(N)-1:0]              snp_src,
  input  logic [AW-$clog2(LINE_BYTES)-1:0]  snp_line,
  output logic                              snp_ack,
  output logic [N-1:0]                      rsp_valid,
  output logic [N-1:0]                      rsp_fail,
  output logic [N-1:0]                      mem_we,
  output logic [N*AW-1:0]                   mem_addr,
  output logic [N*DW-1:0]                   mem_wdata
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int LW  = AW - OFS;
  localparam int SW  = $clog2(N);
  localparam int CW  = $clog2(HOLD + 2);
  localparam logic [1:0] OP_ST  = 2'd1;
  localparam logic [1:0] OP_LDX = 2'd2;
  localparam logic [1:0] OP_STX = 2'd3;

  logic [N-1:0]  resv_v;
  logic [LW-1:0] resv_line [N];
  logic [LW-1:0] rq_line [N];
  logic [N-1:0]  is_st, is_ldx, is_stx, own_hit, snp_hit;
  logic [N-1:0]  kill, pre, win, clr;
  logic [CW-1:0] hold_cnt;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign rq_line[g] = req_addr[g*AW+OFS +: LW];
    assign is_st[g]   = req_op[2*g +: 2] == OP_ST;
    assign is_ldx[g]  = req_op[2*g +: 2] == OP_LDX;
    assign is_stx[g]  = req_op[2*g +: 2] == OP_STX;
    assign own_hit[g] = resv_v[g] && resv_line[g] == rq_line[g];
    assign snp_hit[g] = snp_valid && resv_v[g] && resv_line[g] == snp_line &&
                        snp_src != SW'(g);
    assign pre[g]     = is_stx[g] && own_hit[g] && !kill[g];
  end

  assign snp_ack = snp_valid && (~|snp_hit || hold_cnt == CW'(HOLD));

  always_comb begin
    for (int i = 0; i < N; i++) begin
      kill[i] = snp_ack && snp_hit[i];
      if (SELF_STORE_BREAKS != 0 && is_st[i] && own_hit[i]) kill[i] = 1'b1;
      for (int j = 0; j < N; j++)
        if (j != i && is_st[j] && rq_line[j] == resv_line[i]) kill[i] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      win[i] = pre[i];
      for (int j = 0; j < i; j++)
        if (pre[j] && rq_line[j] == rq_line[i]) win[i] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      clr[i] = kill[i] || is_stx[i];
      for (int j = 0; j < N; j++)
        if (j != i && win[j] && rq_line[j] == resv_line[i]) clr[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_v    <= '0;
      for (int i = 0; i < N; i++) resv_line[i] <= '0;
      rsp_valid <= '0;
      rsp_fail  <= '0;
      mem_we    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      hold_cnt  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (is_ldx[i]) begin
          resv_v[i]    <= 1'b1;
          resv_line[i] <= rq_line[i];
        end else if (clr[i]) begin
          resv_v[i]    <= 1'b0;
        end
      end
      rsp_valid <= is_stx;
      rsp_fail  <= is_stx & ~win;
      mem_we    <= is_st | win;
      mem_addr  <= req_addr;
      mem_wdata <= req_wdata;
      hold_cnt  <= (snp_valid && !snp_ack) ? hold_cnt + CW'(1) : '0;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int N          = 4,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int HOLD       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*N-1:0]  req_op,
  input logic [N-1:0]    resv_v,
  input logic            snp_valid,
  input logic            snp_ack,
  input logic [N-1:0]    rsp_valid,
  input logic [N-1:0]    rsp_fail,
  input logic [N-1:0]    mem_we,
  input logic [N*AW-1:0] mem_addr
);
  localparam int OFS = $clog2(LINE_BYTES);
  int wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= 0;
    else        wait_cnt <= (snp_valid && !snp_ack) ? wait_cnt + 1 : 0;
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= HOLD); // R7

  for (genvar i = 0; i < N; i++) begin : g_core
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_op[2*i +: 2] == 2'd3 |=> rsp_valid[i]); // R2
    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] && rsp_fail[i] |-> !mem_we[i]); // R2
    AST_PASS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] && !rsp_fail[i] |-> mem_we[i]); // R2
    AST_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      req_op[2*i +: 2] == 2'd3 && !resv_v[i] |=> rsp_fail[i]); // R3
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid[i] && !rsp_fail[i] && rsp_valid[j] && !rsp_fail[j] |->
        ((mem_addr[i*AW +: AW] ^ mem_addr[j*AW +: AW]) >> OFS) != 0); // R9
    end
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .N(N), .AW(AW), .LINE_BYTES(LINE_BYTES), .HOLD(HOLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_op(req_op), .resv_v(resv_v),
  .snp_valid(snp_valid), .snp_ack(snp_ack), .rsp_valid(rsp_valid),
  .rsp_fail(rsp_fail), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int N = 4, AW = 32, DW = 32;
  localparam logic [1:0] ST = 2'd1, LDX = 2'd2, STX = 2'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;
  logic [2*N-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic            snp_valid;
  logic [1:0]      snp_src;
  logic [25:0]     snp_line;
  logic            snp_ack, b_snp_ack;
  logic [N-1:0]    rsp_valid, rsp_fail, mem_we, b_rsp_valid, b_rsp_fail, b_mem_we;
  logic [N*AW-1:0] mem_addr, b_mem_addr;
  logic [N*DW-1:0] mem_wdata, b_mem_wdata;

  llsc_monitor #(.N(N), .AW(AW), .DW(DW), .LINE_BYTES(64), .SELF_STORE_BREAKS(1), .HOLD(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .snp_valid(snp_valid), .snp_src(snp_src), .snp_line(snp_line), .snp_ack(snp_ack),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  llsc_monitor #(.N(N), .AW(AW), .DW(DW), .LINE_BYTES(64), .SELF_STORE_BREAKS(0), .HOLD(0)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .snp_valid(snp_valid), .snp_src(snp_src), .snp_line(snp_line), .snp_ack(b_snp_ack),
    .rsp_valid(b_rsp_valid), .rsp_fail(b_rsp_fail), .mem_we(b_mem_we),
    .mem_addr(b_mem_addr), .mem_wdata(b_mem_wdata));

  typedef struct {
    int cyc; int core; bit sc; bit fail; bit we;
    logic [31:0] addr; logic [31:0] data; string tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic put(int c, logic [1:0] op, logic [31:0] a, logic [31:0] d, bit efail, string tag);
    item_t it;
    req_op[2*c +: 2]    = op;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = d;
    it.cyc = cyc; it.core = c; it.addr = a; it.data = d; it.tag = tag;
    if (op == ST)  begin it.sc = 0; it.fail = 0; it.we = 1; sbq.push_back(it); end
    if (op == STX) begin it.sc = 1; it.fail = efail; it.we = !efail; sbq.push_back(it); end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    req_op = '0;
  endtask

  task automatic snoop_wait(int src, logic [31:0] a, output int waits, output bit b_first);
    snp_src = src[1:0]; snp_line = a[31:6]; snp_valid = 1'b1; waits = 0;
    #1;
    b_first = b_snp_ack;
    while (!snp_ack && waits < 20) begin
      @(posedge clk); @(negedge clk); req_op = '0; #1; waits++;
    end
    @(posedge clk); @(negedge clk); req_op = '0;
    snp_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    logic [N-1:0] seen;
    item_t it;
    seen = '0;
    while (sbq.size() > 0 && sbq[0].cyc == cyc - 1) begin
      it = sbq.pop_front();
      seen[it.core] = 1'b1;
      chk(rsp_valid[it.core] == it.sc, {it.tag, " rsp_valid"}, 64'(rsp_valid[it.core]), 64'(it.sc));
      if (it.sc) chk(rsp_fail[it.core] == it.fail, {it.tag, " rsp_fail"}, 64'(rsp_fail[it.core]), 64'(it.fail));
      chk(mem_we[it.core] == it.we, {it.tag, " mem_we"}, 64'(mem_we[it.core]), 64'(it.we));
      if (it.we) begin
        chk(mem_addr[it.core*AW +: AW] == it.addr, {it.tag, " mem_addr"}, 64'(mem_addr[it.core*AW +: AW]), 64'(it.addr));
        chk(mem_wdata[it.core*DW +: DW] == it.data, {it.tag, " mem_wdata"}, 64'(mem_wdata[it.core*DW +: DW]), 64'(it.data));
      end
    end
    for (int c = 0; c < N; c++)
      if ((rsp_valid[c] || mem_we[c]) && !seen[c])
        chk(1'b0, "R2 unexpected output activity", 64'({rsp_valid[c], mem_we[c]}), 64'(0));
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(0), 64'(1));
    finish_run();
  end

  initial begin
    int w; bit bf;
    rst_n = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    snp_valid = 1'b0; snp_src = '0; snp_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 0 && mem_we == 0, "R2 reset outputs", 64'({rsp_valid, mem_we}), 64'(0));
    chk(snp_ack == 1'b0, "R2 reset snp_ack", 64'(snp_ack), 64'(0));
    rst_n = 1'b1;
    step();

    put(0, STX, 32'h1000, 32'hA0, 1, "R3 no reservation"); step();

    put(0, LDX, 32'h1000, 0, 0, ""); step();
    put(0, STX, 32'h1038, 32'hA1, 0, "R1 same line other word"); step();
    put(0, STX, 32'h1000, 32'hA2, 1, "R8 cleared by previous SC"); step();

    put(1, LDX, 32'h1000, 0, 0, ""); step();
    put(1, STX, 32'h1040, 32'hA3, 1, "R1 next line misses"); step();

    put(2, LDX, 32'h1000, 0, 0, ""); step();
    put(2, LDX, 32'h2000, 0, 0, ""); step();
    put(2, STX, 32'h1000, 32'hA4, 1, "R8 old line replaced"); step();
    put(2, LDX, 32'h1000, 0, 0, ""); step();
    put(2, LDX, 32'h2000, 0, 0, ""); step();
    put(2, STX, 32'h2004, 32'hA5, 0, "R8 new line live"); step();

    put(0, LDX, 32'h1000, 0, 0, ""); step();
    put(1, ST, 32'h1010, 32'hB0, 0, "R10 plain store forwarded"); step();
    put(0, STX, 32'h1000, 32'hA6, 1, "R4 remote store same line"); step();
    put(0, LDX, 32'h1000, 0, 0, ""); step();
    put(1, ST, 32'h3000, 32'hB1, 0, "R10 plain store forwarded"); step();
    put(0, STX, 32'h1000, 32'hA7, 0, "R4 remote store other line"); step();

    put(0, LDX, 32'h1000, 0, 0, ""); step();
    put(0, ST, 32'h1008, 32'hB2, 0, "R10 own plain store"); step();
    put(0, STX, 32'h1000, 32'hA8, 1, "R5 own store breaks"); step();
    chk(b_rsp_valid[0] && !b_rsp_fail[0], "R5 own store kept when disabled",
        64'({b_rsp_valid[0], b_rsp_fail[0]}), 64'(2));
    chk(b_mem_we[0] && b_mem_wdata[DW-1:0] == 32'hA8, "R5 write forwarded when disabled",
        64'(b_mem_we[0]), 64'(1));

    put(1, LDX, 32'h1000, 0, 0, ""); put(2, LDX, 32'h1004, 0, 0, ""); step();
    put(1, STX, 32'h1000, 32'hC1, 0, "R9 lower index wins");
    put(2, STX, 32'h1004, 32'hC2, 1, "R9 higher index loses"); step();
    put(0, LDX, 32'h1000, 0, 0, ""); put(3, LDX, 32'h2000, 0, 0, ""); step();
    put(0, STX, 32'h1000, 32'hC3, 0, "R9 distinct lines both win");
    put(3, STX, 32'h2000, 32'hC4, 0, "R9 distinct lines both win"); step();

    put(0, LDX, 32'h1000, 0, 0, ""); step();
    snoop_wait(1, 32'h1020, w, bf);
    chk(w == 4, "R7 held for full hold-off", 64'(w), 64'(4));
    chk(bf == 1'b1, "R7 immediate ack without hold-off", 64'(bf), 64'(1));
    put(0, STX, 32'h1000, 32'hD0, 1, "R6 remote snoop clears"); step();

    put(0, LDX, 32'h1000, 0, 0, ""); step();
    snoop_wait(0, 32'h1000, w, bf);
    chk(w == 0, "R6 owner snoop not delayed", 64'(w), 64'(0));
    put(0, STX, 32'h1000, 32'hD1, 0, "R6 owner snoop keeps reservation"); step();

    put(0, LDX, 32'h1000, 0, 0, ""); step();
    put(0, STX, 32'h1000, 32'hD2, 0, "R7 SC completes during hold");
    snoop_wait(2, 32'h1000, w, bf);
    chk(w == 1, "R7 early release after SC", 64'(w), 64'(1));
    step();

    begin
      bit [2:0] pend;
      int retries [3];
      int bsucc;
      pend = 3'b111; bsucc = 0;
      for (int c = 0; c < 3; c++) retries[c] = 0;
      snp_src = 2'd3; snp_line = 26'h40; snp_valid = 1'b1;
      for (int r = 0; r < 8 && pend != 0; r++) begin
        int low;
        low = pend[0] ? 0 : (pend[1] ? 1 : 2);
        for (int c = 0; c < 3; c++) if (pend[c]) put(c, LDX, 32'h1000 + 4*c, 0, 0, "");
        step();
        for (int c = 0; c < 3; c++)
          if (pend[c]) put(c, STX, 32'h1000 + 8*c, 32'hE0 + c, c != low, "R11 contention round");
        step();
        for (int c = 0; c < 3; c++)
          if (pend[c]) begin
            if (b_rsp_valid[c] && !b_rsp_fail[c]) bsucc++;
            if (rsp_fail[c]) retries[c]++;
            else pend[c] = 1'b0;
          end
      end
      snp_valid = 1'b0;
      chk(pend == 0, "R11 all cores succeed", 64'(pend), 64'(0));
      for (int c = 0; c < 3; c++)
        chk(retries[c] == c, "R11 retry count", 64'(retries[c]), 64'(c));
      chk(bsucc == 0, "R11 starvation without hold-off", 64'(bsucc), 64'(0));
    end

    step(); step();
    chk(sbq.size() == 0, "R2 all responses seen", 64'(sbq.size()), 64'(0));
    finish_run();
  end
endmodule